// File: doc/BRIEF.md
# Audio FIFO Threshold and Interrupt Unit

This block sits between the register bus of an audio serial port and its bit-level shifter. It holds one transmit FIFO, filled by software and drained by the serial side, and one receive FIFO, filled by the serial side and drained by software. Both carry 16-bit samples. The block reports the occupancy and level flags of each FIFO. It compares each occupancy against a per-direction 6-bit threshold to request DMA service.

The block records error and level events in a sticky status word. It masks that word with per-event enables and a global enable, and it drives one interrupt line from the result. Software acknowledges events by writing ones to a clear register.

Register map, by word address on `reg_addr`:
- 0 control: bit 0 transmit FIFO enable, bit 1 receive FIFO enable, bit 2 transmit DMA enable, bit 3 receive DMA enable, bits 13:8 transmit threshold, bits 21:16 receive threshold.
- 1 transmit data: a write pushes bits 15:0.
- 2 receive data: a read pops one sample.
- 3 interrupt enable.
- 4 status.
- 5 clear.
- 6 FIFO status.

Top module: `audio_fifo_irq_unit`

## Requirements
- R1: Each FIFO returns words in the order they were written. A write to address 1 pushes a transmit word, and `ser_tx_data` shows the head word while `ser_tx_valid` is high. `ser_rx_push` stores `ser_rx_data`.
- R2: Address 6 reads back both FIFOs. The receive fields sit in bits 9:0 and the transmit fields in bits 25:16. Within each group, bits 5:0 hold the count (0 to 32), bit 6 is empty (count 0), bit 7 is almost-empty (count 4 or less), bit 8 is full (count 32) and bit 9 is almost-full (count 28 or more).
- R3: A push into a full FIFO is dropped and latches an overflow event. This is status bit 0 for receive and bit 6 for transmit. A pop in the same cycle does not change this.
- R4: A pop from an empty enabled FIFO latches a starve event. This is status bit 1 for receive (a software read) and bit 7 for transmit (a serial pop).
- R5: A read of address 2 returns the head sample in bits 15:0 and a valid flag in bit 16. The valid flag is 1 only when the receive FIFO is enabled and held data.
- R6: `tx_dma_req` is high while transmit DMA is enabled, the transmit FIFO is enabled, and the transmit count is at or below the transmit threshold.
- R7: `rx_dma_req` is high while receive DMA is enabled, the receive FIFO is enabled, and the receive count is at or above the receive threshold.
- R8: Status bits 12:0 are sticky. A bit clears only when a 1 is written to the same bit of address 5. Level events are re-latched every cycle in which they hold, and a set wins over a clear. Level events of a disabled FIFO do not latch. The receive level bits are 2 almost-full, 3 full, 4 almost-empty and 5 empty. The transmit level bits are 8 to 11 in the same order.
- R9: `irq` is the OR of the status bits whose enable bit (address 3, bits 12:0) is set, gated by the global enable at bit 14. A status read returns `irq` in bit 13.
- R10: Clearing a FIFO enable empties that FIFO and sets its count to zero. Pushes and pops to a disabled FIFO are ignored and latch no event.
- R11: Status bit 12 latches whenever the serial side moves a word: a successful transmit pop or a successful receive push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 2) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ser_tx_pop | input | 1 | Serial side takes the transmit head word |
| ser_tx_data | output | 16 | Transmit head word |
| ser_tx_valid | output | 1 | Transmit FIFO holds data |
| ser_rx_push | input | 1 | Serial side delivers a receive word |
| ser_rx_data | input | 16 | Receive word |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check the following on every cycle:
- Count bounds.
- Dropping a push into a full transmit FIFO.
- The flush that follows a disabled cycle.
- Stickiness of the status word against the clear writes.
- That each DMA request agrees with its threshold.
- That the interrupt never fires with the global enable off.

The directed scenarios cover what needs a history of stimulus:
- Word ordering, and confirmation that the overflowing word was really lost.
- The exact almost-empty and almost-full boundaries.
- The data-valid flag on an empty read.
- Re-latching of a persistent level event after a clear.
- That writes to a disabled FIFO leave no trace.

// File: rtl/afiu_pkg.sv
// Shared constants for the audio FIFO threshold and interrupt unit.
// Assumes word addressing on a 3-bit register address.
package afiu_pkg;
    localparam int SAMPLE_W = 16;
    localparam int FIFO_DEPTH = 32;
    localparam int THR_W = 6;
    localparam int AE_LEVEL = 4;
    localparam int AF_LEVEL = 28;
    localparam int NUM_EV = 13;
    localparam int GEN_BIT = 14;
    localparam int PEND_BIT = 13;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_TXDATA = 3'd1,
        A_RXDATA = 3'd2,
        A_IRQEN = 3'd3,
        A_STAT = 3'd4,
        A_CLEAR = 3'd5,
        A_LEVELS = 3'd6
    } afiu_addr_e;

    // Event positions in the status word
    localparam int EV_RX_OVF = 0;
    localparam int EV_RX_STARVE = 1;
    localparam int EV_RX_AFULL = 2;
    localparam int EV_RX_FULL = 3;
    localparam int EV_RX_AEMPTY = 4;
    localparam int EV_RX_EMPTY = 5;
    localparam int EV_TX_OVF = 6;
    localparam int EV_TX_STARVE = 7;
    localparam int EV_TX_AFULL = 8;
    localparam int EV_TX_FULL = 9;
    localparam int EV_TX_AEMPTY = 10;
    localparam int EV_TX_EMPTY = 11;
    localparam int EV_WORD = 12;
endpackage

// File: rtl/afiu_fifo.sv
// Synchronous FIFO with occupancy count, level flags and drop/starve strobes.
// Assumes DEPTH is a power of two. A push into a full FIFO is dropped even
// when a pop happens in the same cycle. While 'enable' is low the FIFO is
// held empty and ignores traffic.
module afiu_fifo #(
    parameter int DW = 16,
    parameter int DEPTH = 32,
    parameter int AE_LVL = 4,
    parameter int AF_LVL = 28,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          aempty,
    output logic          full,
    output logic          afull,
    output logic          push_ok,
    output logic          push_drop,
    output logic          pop_ok,
    output logic          pop_drop
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Level flags derived from the occupancy count
    always_comb begin
        empty  = (count == '0);
        full   = (count == CW'(DEPTH));
        aempty = (count <= CW'(AE_LVL));
        afull  = (count >= CW'(AF_LVL));
    end

    // Accept or reject the requests of this cycle
    always_comb begin
        push_ok   = enable && push && !full;
        push_drop = enable && push && full;
        pop_ok    = enable && pop && !empty;
        pop_drop  = enable && pop && empty;
    end

    assign head_data = mem[rd_ptr];

    // Sample storage, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and count update, flushed while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/afiu_irq_latch.sv
// Sticky event latches with per-event enable and a global interrupt gate.
// A set in the same cycle as a clear leaves the bit set.
module afiu_irq_latch #(
    parameter int NEV = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_set,
    input  logic [NEV-1:0] ev_clr,
    input  logic [NEV-1:0] ev_en,
    input  logic           glob_en,
    output logic [NEV-1:0] ev_stat,
    output logic           irq
);
    for (genvar g = 0; g < NEV; g++) begin : g_bit
        // One latch per event: a set dominates, else a clear drops it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ev_stat[g] <= 1'b0;
            end else if (ev_set[g]) begin
                ev_stat[g] <= 1'b1;
            end else if (ev_clr[g]) begin
                ev_stat[g] <= 1'b0;
            end
        end
    end

    // Masked summary drives the interrupt line
    always_comb begin
        irq = glob_en && |(ev_stat & ev_en);
    end
endmodule

// File: rtl/audio_fifo_irq_unit.sv
// Top of the audio FIFO threshold and interrupt unit: register decode,
// transmit and receive FIFOs, DMA threshold compare and event latches.
// Assumes a single-cycle register strobe; reads are combinational and a
// read of the receive data address pops at the following clock edge.
module audio_fifo_irq_unit
    import afiu_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int TW = THR_W,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int MW = (CW > TW) ? CW : TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          ser_tx_pop,
    output logic [DW-1:0] ser_tx_data,
    output logic          ser_tx_valid,
    input  logic          ser_rx_push,
    input  logic [DW-1:0] ser_rx_data,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          irq
);
    logic          tx_en_q, rx_en_q, tx_dma_en_q, rx_dma_en_q, irq_gen_q;
    logic [TW-1:0] tx_thr_q, rx_thr_q;
    logic [NUM_EV-1:0] irq_en_q;
    logic [NUM_EV-1:0] stat;
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] clr_vec;

    logic          wr_txdata, rd_rxdata, wr_clear;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_empty, tx_aempty, tx_full, tx_afull;
    logic          rx_empty, rx_aempty, rx_full, rx_afull;
    logic          tx_push_ok, tx_push_drop, tx_pop_ok, tx_pop_drop;
    logic          rx_push_ok, rx_push_drop, rx_pop_ok, rx_pop_drop;
    logic [DW-1:0] rx_head;

    // Register strobes for the side-effecting addresses
    always_comb begin
        wr_txdata = reg_wr && (reg_addr == A_TXDATA);
        wr_clear  = reg_wr && (reg_addr == A_CLEAR);
        rd_rxdata = reg_rd && (reg_addr == A_RXDATA);
        clr_vec   = wr_clear ? reg_wdata[NUM_EV-1:0] : '0;
    end

    // Control and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q     <= 1'b0;
            rx_en_q     <= 1'b0;
            tx_dma_en_q <= 1'b0;
            rx_dma_en_q <= 1'b0;
            tx_thr_q    <= '0;
            rx_thr_q    <= '0;
            irq_en_q    <= '0;
            irq_gen_q   <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                tx_en_q     <= reg_wdata[0];
                rx_en_q     <= reg_wdata[1];
                tx_dma_en_q <= reg_wdata[2];
                rx_dma_en_q <= reg_wdata[3];
                tx_thr_q    <= reg_wdata[8 +: TW];
                rx_thr_q    <= reg_wdata[16 +: TW];
            end else if (reg_addr == A_IRQEN) begin
                irq_en_q  <= reg_wdata[NUM_EV-1:0];
                irq_gen_q <= reg_wdata[GEN_BIT];
            end
        end
    end

    afiu_fifo #(
        .DW(DW), .DEPTH(DEPTH), .AE_LVL(AE_LEVEL), .AF_LVL(AF_LEVEL)
    ) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .enable(tx_en_q),
        .push(wr_txdata), .push_data(reg_wdata[DW-1:0]),
        .pop(ser_tx_pop), .head_data(ser_tx_data),
        .count(tx_cnt), .empty(tx_empty), .aempty(tx_aempty),
        .full(tx_full), .afull(tx_afull),
        .push_ok(tx_push_ok), .push_drop(tx_push_drop),
        .pop_ok(tx_pop_ok), .pop_drop(tx_pop_drop)
    );

    afiu_fifo #(
        .DW(DW), .DEPTH(DEPTH), .AE_LVL(AE_LEVEL), .AF_LVL(AF_LEVEL)
    ) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .enable(rx_en_q),
        .push(ser_rx_push), .push_data(ser_rx_data),
        .pop(rd_rxdata), .head_data(rx_head),
        .count(rx_cnt), .empty(rx_empty), .aempty(rx_aempty),
        .full(rx_full), .afull(rx_afull),
        .push_ok(rx_push_ok), .push_drop(rx_push_drop),
        .pop_ok(rx_pop_ok), .pop_drop(rx_pop_drop)
    );

    // Gather the event sources that feed the sticky status word
    always_comb begin
        ev_set               = '0;
        ev_set[EV_RX_OVF]    = rx_push_drop;
        ev_set[EV_RX_STARVE] = rx_pop_drop;
        ev_set[EV_RX_AFULL]  = rx_en_q && rx_afull;
        ev_set[EV_RX_FULL]   = rx_en_q && rx_full;
        ev_set[EV_RX_AEMPTY] = rx_en_q && rx_aempty;
        ev_set[EV_RX_EMPTY]  = rx_en_q && rx_empty;
        ev_set[EV_TX_OVF]    = tx_push_drop;
        ev_set[EV_TX_STARVE] = tx_pop_drop;
        ev_set[EV_TX_AFULL]  = tx_en_q && tx_afull;
        ev_set[EV_TX_FULL]   = tx_en_q && tx_full;
        ev_set[EV_TX_AEMPTY] = tx_en_q && tx_aempty;
        ev_set[EV_TX_EMPTY]  = tx_en_q && tx_empty;
        ev_set[EV_WORD]      = tx_pop_ok || rx_push_ok;
    end

    afiu_irq_latch #(.NEV(NUM_EV)) u_irq (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(clr_vec),
        .ev_en(irq_en_q), .glob_en(irq_gen_q), .ev_stat(stat), .irq(irq)
    );

    // Threshold compare for the DMA requests
    always_comb begin
        tx_dma_req   = tx_dma_en_q && tx_en_q && (MW'(tx_cnt) <= MW'(tx_thr_q));
        rx_dma_req   = rx_dma_en_q && rx_en_q && (MW'(rx_cnt) >= MW'(rx_thr_q));
        ser_tx_valid = tx_en_q && !tx_empty;
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]         = tx_en_q;
                reg_rdata[1]         = rx_en_q;
                reg_rdata[2]         = tx_dma_en_q;
                reg_rdata[3]         = rx_dma_en_q;
                reg_rdata[8 +: TW]   = tx_thr_q;
                reg_rdata[16 +: TW]  = rx_thr_q;
            end
            A_RXDATA: begin
                reg_rdata[DW-1:0] = rx_head;
                reg_rdata[DW]     = rx_en_q && !rx_empty;
                if (rx_en_q && rx_empty) begin
                    reg_rdata[DW-1:0] = '0;
                end
            end
            A_IRQEN: begin
                reg_rdata[NUM_EV-1:0] = irq_en_q;
                reg_rdata[GEN_BIT]    = irq_gen_q;
            end
            A_STAT: begin
                reg_rdata[NUM_EV-1:0] = stat;
                reg_rdata[PEND_BIT]   = irq;
            end
            A_LEVELS: begin
                reg_rdata[15:0]  = 16'({rx_afull, rx_full, rx_aempty, rx_empty, rx_cnt});
                reg_rdata[31:16] = 16'({tx_afull, tx_full, tx_aempty, tx_empty, tx_cnt});
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/afiu_checker.sv
// Property checker for the audio FIFO threshold and interrupt unit, bound
// to the top module. Observes counts, enables, strobes and the status word.
module afiu_checker #(
    parameter int DEPTH = 32,
    parameter int TW = 6,
    parameter int NEV = 13,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int MW = (CW > TW) ? CW : TW
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  tx_cnt,
    input logic [CW-1:0]  rx_cnt,
    input logic           tx_en_q,
    input logic           rx_en_q,
    input logic           tx_full,
    input logic           wr_txdata,
    input logic           ser_tx_pop,
    input logic [NEV-1:0] stat,
    input logic [NEV-1:0] clr_vec,
    input logic           irq,
    input logic           irq_gen_q,
    input logic           tx_dma_req,
    input logic           rx_dma_req,
    input logic [TW-1:0]  tx_thr_q,
    input logic [TW-1:0]  rx_thr_q
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_q && tx_full && wr_txdata && !ser_tx_pop) |=> (tx_cnt == CW'(DEPTH)));

    assert_tx_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (MW'(tx_cnt) <= MW'(tx_thr_q)));

    assert_rx_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (MW'(rx_cnt) >= MW'(rx_thr_q)));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat) & ~$past(clr_vec)) & ~stat) == '0));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_gen_q);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_q && !rx_en_q) |=> (tx_cnt == '0 && rx_cnt == '0));
endmodule

bind audio_fifo_irq_unit afiu_checker #(
    .DEPTH(DEPTH), .TW(TW), .NEV(afiu_pkg::NUM_EV)
) u_afiu_checker (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_en_q(tx_en_q), .rx_en_q(rx_en_q), .tx_full(tx_full),
    .wr_txdata(wr_txdata), .ser_tx_pop(ser_tx_pop), .stat(stat),
    .clr_vec(clr_vec), .irq(irq), .irq_gen_q(irq_gen_q),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_thr_q(tx_thr_q), .rx_thr_q(rx_thr_q)
);

// File: tb/audio_fifo_irq_unit_bench.sv
// Directed bench for the audio FIFO threshold and interrupt unit.
module audio_fifo_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ser_tx_pop = 1'b0;
    logic [15:0] ser_tx_data;
    logic        ser_tx_valid;
    logic        ser_rx_push = 1'b0;
    logic [15:0] ser_rx_data = '0;
    logic        tx_dma_req, rx_dma_req, irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    audio_fifo_irq_unit u_audio_fifo_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_tx_valid(ser_tx_valid), .ser_rx_push(ser_rx_push),
        .ser_rx_data(ser_rx_data), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic spop(output logic [15:0] d);
        @(negedge clk);
        d = ser_tx_data;
        ser_tx_pop = 1'b1;
        @(negedge clk);
        ser_tx_pop = 1'b0;
    endtask

    task automatic spush(input logic [15:0] d);
        @(negedge clk);
        ser_rx_push = 1'b1; ser_rx_data = d;
        @(negedge clk);
        ser_rx_push = 1'b0;
    endtask

    task automatic fresh(input logic [31:0] ctrl);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h1FFF);
        wr(3'd3, 32'h0);
        wr(3'd0, ctrl);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        chk("R9 irq after reset", {31'b0, irq}, 32'h0);
        chk("R6 tx dma after reset", {31'b0, tx_dma_req}, 32'h0);
        chk("R7 rx dma after reset", {31'b0, rx_dma_req}, 32'h0);
        peek(3'd4, v); chk("R8 status after reset", v, 32'h0);
        peek(3'd6, v); chk("R2 levels after reset", v, 32'h00C0_00C0);
    endtask

    task automatic test_tx_order();
        logic [31:0] v; logic [15:0] d;
        fresh(32'h1);
        wr(3'd1, 32'hA1A1); wr(3'd1, 32'hB2B2); wr(3'd1, 32'hC3C3);
        peek(3'd6, v); chk("R2 tx count 3", {26'b0, v[21:16]}, 32'd3);
        chk("R1 tx valid", {31'b0, ser_tx_valid}, 32'h1);
        spop(d); chk("R1 tx word 0", {16'b0, d}, 32'hA1A1);
        spop(d); chk("R1 tx word 1", {16'b0, d}, 32'hB2B2);
        spop(d); chk("R1 tx word 2", {16'b0, d}, 32'hC3C3);
        peek(3'd4, v); chk("R11 word transferred", {31'b0, v[12]}, 32'h1);
        spop(d);
        peek(3'd4, v); chk("R4 tx starve", {31'b0, v[7]}, 32'h1);
    endtask

    task automatic test_tx_dma();
        logic [15:0] d;
        fresh(32'h0000_0405);
        @(negedge clk); chk("R6 tx req at count 0", {31'b0, tx_dma_req}, 32'h1);
        for (int i = 0; i < 5; i++) wr(3'd1, 32'(i));
        @(negedge clk); chk("R6 tx req at count 5", {31'b0, tx_dma_req}, 32'h0);
        spop(d);
        @(negedge clk); chk("R6 tx req at count 4", {31'b0, tx_dma_req}, 32'h1);
    endtask

    task automatic test_rx_path();
        logic [31:0] v;
        fresh(32'h0002_000A);
        @(negedge clk); chk("R7 rx req at count 0", {31'b0, rx_dma_req}, 32'h0);
        spush(16'h1234);
        @(negedge clk); chk("R7 rx req at count 1", {31'b0, rx_dma_req}, 32'h0);
        spush(16'h5678);
        @(negedge clk); chk("R7 rx req at count 2", {31'b0, rx_dma_req}, 32'h1);
        rd(3'd2, v); chk("R5 rx read 0", v, 32'h0001_1234);
        rd(3'd2, v); chk("R5 rx read 1", v, 32'h0001_5678);
        rd(3'd2, v); chk("R5 rx empty read valid", {31'b0, v[16]}, 32'h0);
        peek(3'd4, v); chk("R4 rx starve", {31'b0, v[1]}, 32'h1);
    endtask

    task automatic test_overflow();
        logic [31:0] v; logic [15:0] d;
        fresh(32'h1);
        for (int i = 0; i < 33; i++) wr(3'd1, 32'h100 + 32'(i));
        peek(3'd4, v); chk("R3 tx overflow latched", {31'b0, v[6]}, 32'h1);
        peek(3'd6, v); chk("R2 full levels", {22'b0, v[25:16]}, 32'h320);
        for (int i = 0; i < 32; i++) spop(d);
        chk("R3 dropped word absent", {16'b0, d}, 32'h011F);
        chk("R1 tx drained", {31'b0, ser_tx_valid}, 32'h0);
    endtask

    task automatic test_irq_clear();
        logic [31:0] v;
        wr(3'd3, 32'h0000_4040);
        @(negedge clk); chk("R9 irq on overflow", {31'b0, irq}, 32'h1);
        peek(3'd4, v); chk("R9 pending bit", {31'b0, v[13]}, 32'h1);
        wr(3'd5, 32'h40);
        @(negedge clk); chk("R9 irq after clear", {31'b0, irq}, 32'h0);
        peek(3'd4, v); chk("R8 overflow cleared", {31'b0, v[6]}, 32'h0);
        wr(3'd5, 32'h800);
        peek(3'd4, v); chk("R8 level re-latched", {31'b0, v[11]}, 32'h1);
        wr(3'd3, 32'h0000_0800);
        @(negedge clk); chk("R9 global off", {31'b0, irq}, 32'h0);
        wr(3'd3, 32'h0000_4800);
        @(negedge clk); chk("R9 global on", {31'b0, irq}, 32'h1);
    endtask

    task automatic test_levels();
        logic [31:0] v;
        fresh(32'h1);
        for (int i = 0; i < 4; i++) wr(3'd1, 32'(i));
        peek(3'd6, v); chk("R2 almost-empty at 4", {31'b0, v[23]}, 32'h1);
        wr(3'd1, 32'h4);
        peek(3'd6, v); chk("R2 almost-empty at 5", {31'b0, v[23]}, 32'h0);
        for (int i = 5; i < 27; i++) wr(3'd1, 32'(i));
        peek(3'd6, v); chk("R2 almost-full at 27", {31'b0, v[25]}, 32'h0);
        wr(3'd1, 32'h1B);
        peek(3'd6, v); chk("R2 almost-full at 28", {31'b0, v[25]}, 32'h1);
    endtask

    task automatic test_flush();
        logic [31:0] v;
        fresh(32'h1);
        for (int i = 0; i < 10; i++) wr(3'd1, 32'(i));
        wr(3'd0, 32'h0);
        peek(3'd6, v); chk("R10 flushed count", {26'b0, v[21:16]}, 32'h0);
        chk("R10 no valid after flush", {31'b0, ser_tx_valid}, 32'h0);
        wr(3'd5, 32'h1FFF);
        wr(3'd1, 32'hDEAD);
        rd(3'd2, v); chk("R10 disabled rx read", {31'b0, v[16]}, 32'h0);
        peek(3'd4, v); chk("R10 no event while disabled", v, 32'h0);
        wr(3'd0, 32'h1);
        peek(3'd6, v); chk("R10 disabled push ignored", {26'b0, v[21:16]}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset();
        test_tx_order();
        test_tx_dma();
        test_rx_path();
        test_overflow();
        test_irq_clear();
        test_levels();
        test_flush();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule